// File: doc/BRIEF.md
# Expansion Bus Command Enable Decoder

This block decides, for every bus cycle, whether the command buffer that drives the expansion bus is opened. On-board peripherals and plug-in cards can answer the same addresses. The decoder therefore closes the buffer for I/O and memory cycles that an enabled on-board device will serve, and opens it for everything else. It also produces expansion-bus memory read and write strobes, and it limits these strobes to the lowest megabyte of address space.

The inputs are the current cycle kind, the DMA and refresh flags, the cycle address, and one enable flag per on-board device. The decoder holds two small configuration registers, written by ordinary I/O write cycles to ports 001Ah and 001Bh. These registers mark which video ROM windows and which video memory windows belong to the on-board video. Outputs are combinational from the inputs and the registers. A register write takes effect from the clock edge that ends the write cycle.

Top module: `cmd_enable_decoder`

## Requirements
- R1: After reset both configuration registers hold zero, so every memory cycle drives `cmdEnN` low (buffer open), even with on-board video enabled.
- R2: While `dmaActive` or `refreshActive` is high, `cmdEnN` is low, whatever the cycle kind and address.
- R3: A non-DMA, non-refresh I/O cycle (`cycType` 1 = I/O read, 2 = I/O write) to an address outside every excluded range drives `cmdEnN` low. I/O ranges are matched on `addr[15:0]`.
- R4: A non-DMA I/O cycle drives `cmdEnN` high when it hits the range of an on-board device whose `onbEn` bit is set: bit 0 floppy 03F0h–03F7h, bit 1 hard disk 01F0h–01F7h, bit 2 serial 03F8h–03FFh, bit 3 parallel 0378h–037Fh, bit 4 video 03B0h–03DFh. With that bit clear, the same cycle drives `cmdEnN` low.
- R5: A non-DMA I/O cycle to 00F0h–00FFh (coprocessor) drives `cmdEnN` high, independent of `onbEn`.
- R6: With `onbEn[4]` set, a non-DMA memory cycle (`cycType` 3 = read, 4 = write) in C0000h–C7FFFh drives `cmdEnN` high when bit 4+k of the 001Ah register is set, where k = `addr[14:13]` selects an 8 KB window.
- R7: With `onbEn[4]` set, a non-DMA memory cycle in A0000h + i·8000h … A0000h + i·8000h + 7FFFh (i = 0..5) drives `cmdEnN` high when bit i of the 001Bh register is set. Addresses from D0000h upward are never claimed.
- R8: With `onbEn[4]` clear, the ROM and video memory windows have no effect and memory cycles drive `cmdEnN` low.
- R9: A non-DMA, non-refresh I/O write with `addr[15:0]` = 001Ah stores `ioData[7:4]`, and one to 001Bh stores `ioData[5:0]`, at the next clock edge. Bits 3:0 of 001Ah and bits 7:6 of 001Bh are ignored.
- R10: `busMemRdN` is low only for memory read cycles and `busMemWrN` only for memory write cycles, and each only when `addr` < 100000h.
- R11: An idle cycle (`cycType` 0, or any code above 4) with no DMA or refresh drives `cmdEnN` high and both strobes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration registers |
| rstN | input | 1 | Active-low asynchronous reset |
| cycType | input | 3 | Cycle kind: 0 idle, 1 I/O read, 2 I/O write, 3 memory read, 4 memory write |
| dmaActive | input | 1 | Current cycle is a DMA cycle |
| refreshActive | input | 1 | Current cycle is a memory refresh |
| addr | input | 24 | Cycle address |
| ioData | input | 8 | Write data of the current I/O cycle |
| onbEn | input | 5 | On-board enables: floppy, hard disk, serial, parallel, video (bit 0 to 4) |
| cmdEnN | output | 1 | Active-low expansion command buffer enable |
| busMemRdN | output | 1 | Active-low expansion memory read strobe, first megabyte only |
| busMemWrN | output | 1 | Active-low expansion memory write strobe, first megabyte only |

## Verification
The assertions check four properties on every cycle. DMA and refresh always win, coprocessor I/O is never passed to the bus, and the two strobes are never low together or outside the first megabyte. A configuration register changes only through a decoded port write, and it then holds exactly the written field. Some behaviour depends on which window bit sits where in each register, and on how the registers interact with the video enable and the address. The bench scenarios show this: they write chosen and random register values and then probe the window edges, the addresses just outside them, and the ignored register bits.

// File: rtl/cmd_dec_pkg.sv
package cmd_dec_pkg;

  typedef enum logic [2:0] {
    CYC_IDLE   = 3'd0,
    CYC_IO_RD  = 3'd1,
    CYC_IO_WR  = 3'd2,
    CYC_MEM_RD = 3'd3,
    CYC_MEM_WR = 3'd4
  } cyc_e;

  // control -> datapath: configuration write strobes
  typedef struct packed {
    logic wrRom;
    logic wrVmem;
  } cfg_wr_t;

  // datapath -> control: fixed I/O range hits
  typedef struct packed {
    logic fdc;
    logic hdd;
    logic ser;
    logic par;
    logic vid;
    logic npx;
  } io_hit_t;

  localparam int ONB_FDC = 0;
  localparam int ONB_HDD = 1;
  localparam int ONB_SER = 2;
  localparam int ONB_PAR = 3;
  localparam int ONB_VID = 4;
  localparam int ONB_W   = 5;

endpackage

// File: rtl/cmd_dec_dp.sv
module cmd_dec_dp
  import cmd_dec_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 8,
  parameter int ROM_WIN = 4,
  parameter int ROM_FIELD_LSB = 4,
  parameter int ROM_WIN_LOG = 13,
  parameter logic [ADDR_W-1:0] ROM_BASE = 24'hC0000,
  parameter int VMEM_WIN = 6,
  parameter int VMEM_WIN_LOG = 15,
  parameter logic [ADDR_W-1:0] VMEM_BASE = 24'hA0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  cfg_wr_t           cfgWr,
  input  logic [DATA_W-1:0] ioData,
  input  logic [ADDR_W-1:0] addr,
  output io_hit_t           ioHit,
  output logic              romHit,
  output logic              vmemHit
);

  localparam int ROM_TAG_W  = ADDR_W - ROM_WIN_LOG;
  localparam int VMEM_TAG_W = ADDR_W - VMEM_WIN_LOG;

  logic [ROM_WIN-1:0]  regRom;
  logic [VMEM_WIN-1:0] regVmem;
  logic [ROM_WIN-1:0]  romSel;
  logic [VMEM_WIN-1:0] vmemSel;
  logic [15:0]         ioAddr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regRom  <= '0;
      regVmem <= '0;
    end else begin
      if (cfgWr.wrRom)  regRom  <= ioData[ROM_FIELD_LSB +: ROM_WIN];
      if (cfgWr.wrVmem) regVmem <= ioData[0 +: VMEM_WIN];
    end
  end

  for (genvar k = 0; k < ROM_WIN; k++) begin : g_rom
    localparam logic [ROM_TAG_W-1:0] TAG =
      ROM_TAG_W'(ROM_BASE >> ROM_WIN_LOG) + ROM_TAG_W'(k);
    assign romSel[k] = regRom[k] && (addr[ADDR_W-1:ROM_WIN_LOG] == TAG);
  end

  for (genvar i = 0; i < VMEM_WIN; i++) begin : g_vmem
    localparam logic [VMEM_TAG_W-1:0] TAG =
      VMEM_TAG_W'(VMEM_BASE >> VMEM_WIN_LOG) + VMEM_TAG_W'(i);
    assign vmemSel[i] = regVmem[i] && (addr[ADDR_W-1:VMEM_WIN_LOG] == TAG);
  end

  assign romHit  = |romSel;
  assign vmemHit = |vmemSel;

  assign ioAddr = addr[15:0];

  always_comb begin
    ioHit.fdc = (ioAddr >= 16'h03F0) && (ioAddr <= 16'h03F7);
    ioHit.hdd = (ioAddr >= 16'h01F0) && (ioAddr <= 16'h01F7);
    ioHit.ser = (ioAddr >= 16'h03F8) && (ioAddr <= 16'h03FF);
    ioHit.par = (ioAddr >= 16'h0378) && (ioAddr <= 16'h037F);
    ioHit.vid = (ioAddr >= 16'h03B0) && (ioAddr <= 16'h03DF);
    ioHit.npx = (ioAddr >= 16'h00F0) && (ioAddr <= 16'h00FF);
  end

  // R9
  cfg_rom_wr_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgWr.wrRom |=> regRom == $past(ioData[ROM_FIELD_LSB +: ROM_WIN]));

  // R9
  cfg_vmem_wr_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgWr.wrVmem |=> regVmem == $past(ioData[0 +: VMEM_WIN]));

  // R9
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(cfgWr.wrRom || cfgWr.wrVmem) |=> $stable(regRom) && $stable(regVmem));

  // R9
  cfg_wr_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(cfgWr.wrRom && cfgWr.wrVmem));

endmodule

// File: rtl/cmd_dec_ctrl.sv
module cmd_dec_ctrl
  import cmd_dec_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int MB_LOG = 20,
  parameter logic [15:0] PORT_ROM = 16'h001A,
  parameter logic [15:0] PORT_VMEM = 16'h001B
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        cycType,
  input  logic              dmaActive,
  input  logic              refreshActive,
  input  logic [ADDR_W-1:0] addr,
  input  logic [ONB_W-1:0]  onbEn,
  input  io_hit_t           ioHit,
  input  logic              romHit,
  input  logic              vmemHit,
  output cfg_wr_t           cfgWr,
  output logic              cmdEnN,
  output logic              busMemRdN,
  output logic              busMemWrN
);

  cyc_e cyc;
  logic isIo, isMem, busMaster, firstMb, ioClaim, memClaim;

  assign cyc       = cyc_e'(cycType);
  assign isIo      = (cyc == CYC_IO_RD) || (cyc == CYC_IO_WR);
  assign isMem     = (cyc == CYC_MEM_RD) || (cyc == CYC_MEM_WR);
  assign busMaster = dmaActive || refreshActive;
  assign firstMb   = (addr[ADDR_W-1:MB_LOG] == '0);

  always_comb begin
    ioClaim = ioHit.npx
            || (ioHit.fdc && onbEn[ONB_FDC])
            || (ioHit.hdd && onbEn[ONB_HDD])
            || (ioHit.ser && onbEn[ONB_SER])
            || (ioHit.par && onbEn[ONB_PAR])
            || (ioHit.vid && onbEn[ONB_VID]);
    memClaim = onbEn[ONB_VID] && (romHit || vmemHit);
  end

  always_comb begin
    if (busMaster)  cmdEnN = 1'b0;
    else if (isIo)  cmdEnN = ioClaim;
    else if (isMem) cmdEnN = memClaim;
    else            cmdEnN = 1'b1;
  end

  always_comb begin
    cfgWr.wrRom  = (cyc == CYC_IO_WR) && !busMaster && (addr[15:0] == PORT_ROM);
    cfgWr.wrVmem = (cyc == CYC_IO_WR) && !busMaster && (addr[15:0] == PORT_VMEM);
  end

  assign busMemRdN = !((cyc == CYC_MEM_RD) && firstMb);
  assign busMemWrN = !((cyc == CYC_MEM_WR) && firstMb);

  // R2
  dma_refresh_open_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dmaActive || refreshActive) |-> !cmdEnN);

  // R5
  npx_closed_chk: assert property (@(posedge clk) disable iff (!rstN)
    (isIo && !busMaster && addr[15:4] == 12'h00F) |-> cmdEnN);

  // R10
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(!busMemRdN && !busMemWrN));

  // R10
  strobe_low_mb_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busMemRdN || !busMemWrN) |-> (addr < (ADDR_W'(1) << MB_LOG)));

  // R11
  idle_closed_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!isIo && !isMem && !busMaster) |-> cmdEnN && busMemRdN && busMemWrN);

endmodule

// File: rtl/cmd_enable_decoder.sv
module cmd_enable_decoder
  import cmd_dec_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        cycType,
  input  logic              dmaActive,
  input  logic              refreshActive,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] ioData,
  input  logic [ONB_W-1:0]  onbEn,
  output logic              cmdEnN,
  output logic              busMemRdN,
  output logic              busMemWrN
);

  cfg_wr_t cfgWr;
  io_hit_t ioHit;
  logic    romHit, vmemHit;

  cmd_dec_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_dp (
    .clk     (clk),
    .rstN    (rstN),
    .cfgWr   (cfgWr),
    .ioData  (ioData),
    .addr    (addr),
    .ioHit   (ioHit),
    .romHit  (romHit),
    .vmemHit (vmemHit)
  );

  cmd_dec_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .cycType       (cycType),
    .dmaActive     (dmaActive),
    .refreshActive (refreshActive),
    .addr          (addr),
    .onbEn         (onbEn),
    .ioHit         (ioHit),
    .romHit        (romHit),
    .vmemHit       (vmemHit),
    .cfgWr         (cfgWr),
    .cmdEnN        (cmdEnN),
    .busMemRdN     (busMemRdN),
    .busMemWrN     (busMemWrN)
  );

endmodule

// File: tb/test_cmd_enable_decoder.sv
module test_cmd_enable_decoder;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  cycType = 3'd0;
  logic        dmaActive = 1'b0;
  logic        refreshActive = 1'b0;
  logic [23:0] addr = '0;
  logic [7:0]  ioData = '0;
  logic [4:0]  onbEn = '0;
  logic        cmdEnN, busMemRdN, busMemWrN;

  int nTests = 0;
  int nFail = 0;
  bit finished = 0;
  logic [3:0] shRom = '0;
  logic [5:0] shVmem = '0;

  always #5 clk = ~clk;

  cmd_enable_decoder i_cmd_enable_decoder (
    .clk(clk), .rstN(rstN), .cycType(cycType), .dmaActive(dmaActive),
    .refreshActive(refreshActive), .addr(addr), .ioData(ioData),
    .onbEn(onbEn), .cmdEnN(cmdEnN), .busMemRdN(busMemRdN), .busMemWrN(busMemWrN)
  );

  function automatic logic inR(logic [15:0] a, logic [15:0] lo, logic [15:0] hi);
    return (a >= lo) && (a <= hi);
  endfunction

  // expected cmdEnN and the requirement it follows from
  function automatic logic expEn(output string tag);
    logic [15:0] a = addr[15:0];
    logic romH, vmH;
    if (dmaActive || refreshActive) begin tag = "R2"; return 1'b0; end
    if (cycType == 3'd1 || cycType == 3'd2) begin
      if (inR(a, 16'h00F0, 16'h00FF)) begin tag = "R5"; return 1'b1; end
      tag = "R4";
      if (inR(a, 16'h03F0, 16'h03F7)) return onbEn[0];
      if (inR(a, 16'h01F0, 16'h01F7)) return onbEn[1];
      if (inR(a, 16'h03F8, 16'h03FF)) return onbEn[2];
      if (inR(a, 16'h0378, 16'h037F)) return onbEn[3];
      if (inR(a, 16'h03B0, 16'h03DF)) return onbEn[4];
      tag = "R3"; return 1'b0;
    end
    if (cycType == 3'd3 || cycType == 3'd4) begin
      romH = (addr >= 24'hC0000) && (addr < 24'hC8000) && shRom[(addr - 24'hC0000) >> 13];
      vmH  = (addr >= 24'hA0000) && (addr < 24'hD0000) && shVmem[(addr - 24'hA0000) >> 15];
      if (!onbEn[4]) begin tag = "R8"; return 1'b0; end
      if (romH) begin tag = "R6"; return 1'b1; end
      if (vmH)  begin tag = "R7"; return 1'b1; end
      tag = (shRom == 0 && shVmem == 0) ? "R1" : "R7";
      return 1'b0;
    end
    tag = "R11"; return 1'b1;
  endfunction

  task automatic chk(string tag, string what, logic act, logic exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s addr=%h cyc=%0d: actual=%b expected=%b",
               tag, what, addr, cycType, act, exp);
    end
  endtask

  task automatic checkAll();
    string tag;
    logic e, rdE, wrE;
    e = expEn(tag);
    rdE = !(cycType == 3'd3 && addr < 24'h100000);
    wrE = !(cycType == 3'd4 && addr < 24'h100000);
    chk(tag, "cmdEnN", cmdEnN, e);
    chk("R10", "busMemRdN", busMemRdN, rdE);
    chk("R10", "busMemWrN", busMemWrN, wrE);
  endtask

  // drive at negedge, check mid-cycle, commit at posedge
  task automatic cyc(logic [2:0] t, logic [23:0] a, logic [7:0] d = 8'h00,
                     logic dma = 1'b0, logic rf = 1'b0);
    @(negedge clk);
    cycType = t; addr = a; ioData = d; dmaActive = dma; refreshActive = rf;
    #2;
    checkAll();
    @(posedge clk);
    if (t == 3'd2 && !dma && !rf) begin
      if (a[15:0] == 16'h001A) shRom  = d[7:4];
      if (a[15:0] == 16'h001B) shVmem = d[5:0];
    end
  endtask

  initial begin : watchdog
    #2_000_000;
    if (!finished) begin
      nTests++; nFail++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin : stim
    logic [23:0] a;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;

    // R1: reset values leave every memory cycle on the bus
    onbEn = 5'h1F;
    cyc(3'd3, 24'hC0000);
    cyc(3'd4, 24'hA0000);
    cyc(3'd3, 24'hC8000);
    // R11 idle codes
    cyc(3'd0, 24'h003F0);
    cyc(3'd7, 24'h00000);
    // R3, R4, R5 directed
    cyc(3'd1, 24'h00060);
    cyc(3'd1, 24'h003F7);
    cyc(3'd2, 24'h001F0);
    cyc(3'd1, 24'h003DF);
    cyc(3'd1, 24'h003E0);
    onbEn = 5'h00;
    cyc(3'd1, 24'h003F8);
    cyc(3'd1, 24'h0037F);
    cyc(3'd2, 24'h000F0);
    cyc(3'd1, 24'h000FF);
    // R2 override
    onbEn = 5'h1F;
    cyc(3'd1, 24'h000F4, 8'h00, 1'b1, 1'b0);
    cyc(3'd3, 24'h0C000, 8'h00, 1'b0, 1'b1);
    // R9: write during DMA ignored
    cyc(3'd2, 24'h0001A, 8'hF0, 1'b1, 1'b0);
    cyc(3'd3, 24'hC0000);
    // R9 ignored low bits of 1Ah
    cyc(3'd2, 24'h0001A, 8'h0F);
    cyc(3'd3, 24'hC0000);
    // R6 window edges
    cyc(3'd2, 24'h0001A, 8'h50);
    cyc(3'd3, 24'hC0000);
    cyc(3'd3, 24'hC1FFF);
    cyc(3'd3, 24'hC2000);
    cyc(3'd4, 24'hC4000);
    cyc(3'd3, 24'hC7FFF);
    cyc(3'd3, 24'hC8000);
    cyc(3'd3, 24'h1C0000);
    // R7, R9 ignored top bits of 1Bh
    cyc(3'd2, 24'h0001B, 8'hFF);
    cyc(3'd3, 24'hA0000);
    cyc(3'd4, 24'hCFFFF);
    cyc(3'd3, 24'hD0000);
    cyc(3'd3, 24'h9FFFF);
    cyc(3'd2, 24'h0001B, 8'h22);
    cyc(3'd3, 24'hA8000);
    cyc(3'd3, 24'hA0000);
    cyc(3'd3, 24'hC7FFF);
    // R8 video off
    onbEn = 5'h0F;
    cyc(3'd3, 24'hA8000);
    cyc(3'd3, 24'hC0000);
    // R10 above first megabyte
    cyc(3'd3, 24'h100000);
    cyc(3'd4, 24'hFFFFF);

    // random mix
    for (int n = 0; n < 3000; n++) begin
      onbEn = 5'($urandom);
      case ($urandom % 6)
        0: a = 24'($urandom) & 24'h0003FF;
        1: a = 24'($urandom);
        2: a = 24'hA0000 + 24'($urandom % 32'h38000);
        3: a = 24'hBFF00 + 24'($urandom % 32'h10200);
        4: a = {8'($urandom), 16'h001A | 16'($urandom % 2)};
        default: a = 24'($urandom) & 24'h0FFFFF;
      endcase
      cyc(3'($urandom % 6), a, 8'($urandom),
          ($urandom % 10) == 0, ($urandom % 12) == 0);
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule